// File: doc/BRIEF.md
# Battery Charge Cycle Sequencer

This block sequences an autonomous battery charge cycle from digital flags. Comparators and a register file elsewhere on the chip supply the flags. The block qualifies whether a cycle may start. It chooses precharge or fast charge from the battery-low flag. It detects termination and re-arms on a recharge condition or on a toggle of either enable. A safety timer, advanced by a one-second tick, limits how long charging may run.

The block reports four things: a 2-bit phase code for a status register, a drive level for a status LED pin, a one-cycle interrupt pulse when a cycle completes, and a sticky flag for a safety timer fault. The LED pin is low while charging and high when charging is disabled or done. It blinks when there is a fault. The blink comes from a prescaled clock with a parameterised divisor.

Top module: `chg_cycle_ctrl`

## Requirements
- R1: A cycle starts only when all of these hold: the converter is running, the enable bit is 1, the active-low enable pin is 0, the charge-current setting is nonzero, there is no thermistor fault, the FET-disable bit is 0, and there is no timer fault. If any of these is lost, the phase returns to 00 on the next clock.
- R2: The phase code is 00 disabled, 01 precharge, 10 fast charge and 11 done. A start enters 01 if the below-precharge flag is set and 10 otherwise. Phase 01 moves to 10 when that flag clears.
- R3: Phase 10 moves to 11 only when all of these hold: current is below the termination level, the battery is not below the recharge level, DPM is inactive and thermal regulation is inactive.
- R4: In phase 11, the below-recharge flag starts a new cycle.
- R5: In phase 11, a toggle of the enable bit or of the enable pin (deassert, then reassert) starts a new cycle.
- R6: The status pin is 0 in phases 01 and 10 and 1 otherwise. When a timer or thermistor fault is present, it toggles every BLINK_HALF prescaled ticks, with one prescaled tick every BLINK_DIV clocks.
- R7: While the status-disable input is 1, the status pin is held at 1, including during a fault.
- R8: The interrupt output is high for exactly one clock on each entry into phase 11.
- R9: The safety timer counts ticks in phases 01 and 10 only, and is cleared whenever a cycle starts. At TIMER_LIMIT ticks it raises the fault flag and the phase goes to 00.
- R10: The timer fault persists until the user enable (bit 1 and pin 0) is dropped. A recharge condition does not clear it.
- R11: If timer expiry and termination fall in the same clock, expiry wins: the phase goes to 00, the fault is raised and no interrupt is issued.
- R12: After reset, the phase is 00, the status pin is 1, the interrupt is 0 and the fault flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_on | input | 1 | Converter running |
| en_bit | input | 1 | Charge enable register bit |
| en_pin_n | input | 1 | Active-low charge enable pin |
| ichg_nz | input | 1 | Charge current setting is nonzero |
| ts_fault | input | 1 | Thermistor fault |
| fet_dis | input | 1 | Battery FET forced off |
| vbat_lo_pre | input | 1 | Battery below precharge level |
| vbat_lo_rech | input | 1 | Battery below recharge level |
| ibat_lo_term | input | 1 | Charge current below termination level |
| dpm_act | input | 1 | Input DPM loop active |
| treg_act | input | 1 | Thermal regulation active |
| tick_1s | input | 1 | One-clock pulse per second |
| stat_dis | input | 1 | Status pin disable |
| phase | output | 2 | Phase code |
| stat_o | output | 1 | Status pin drive level |
| int_o | output | 1 | Cycle complete interrupt pulse |
| tmr_fault | output | 1 | Safety timer fault |

## Verification
Termination and timer expiry can both become due on the same clock edge. This happens when the last permitted tick arrives just as the battery reaches full. The bench sets up this case by charging for TIMER_LIMIT-1 ticks. It then raises the termination flags and the final tick on the same falling edge. It judges the outcome from the ports: the phase must read 00, the fault flag must be 1, and the interrupt pulse count must not change. The vector table separately shows that the same termination flags, with no tick, do lead to phase 11.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [1:0] {
    PH_DIS  = 2'b00,
    PH_PRE  = 2'b01,
    PH_FAST = 2'b10,
    PH_DONE = 2'b11
  } phase_e;
endpackage

// File: rtl/chg_qual.sv
module chg_qual (
  input  logic conv_on,
  input  logic en_bit,
  input  logic en_pin_n,
  input  logic ichg_nz,
  input  logic ts_fault,
  input  logic fet_dis,
  input  logic tmr_fault,
  output logic user_en,
  output logic start_ok
);
  // user enable is the pair that a host toggles to re-arm
  assign user_en  = en_bit & ~en_pin_n;
  assign start_ok = user_en & conv_on & ichg_nz & ~ts_fault & ~fet_dis & ~tmr_fault;
endmodule

// File: rtl/chg_safety_tmr.sv
module chg_safety_tmr #(
  parameter int LIMIT = 43200
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  input  logic user_en_i,
  output logic expire_o,
  output logic fault_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          fault_q;

  assign expire_o = run_i & tick_i & (cnt_q == CW'(LIMIT - 1));
  assign fault_o  = fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (clr_i || expire_o)   cnt_q <= '0;
      else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
      if (expire_o)            fault_q <= 1'b1;
      else if (!user_en_i)     fault_q <= 1'b0;
    end
  end

  // R9
  fault_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> $past(run_i && tick_i));
  // R10
  fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_q) |-> $past(!user_en_i));
endmodule

// File: rtl/chg_stat_drv.sv
module chg_stat_drv #(
  parameter int DIV  = 50000,
  parameter int HALF = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic charging_i,
  input  logic fault_i,
  input  logic stat_dis_i,
  output logic stat_o
);
  localparam int PW = (DIV  > 1) ? $clog2(DIV)  : 1;
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [PW-1:0] pre_q;
  logic [HW-1:0] half_q;
  logic          blink_q;
  logic          stat_q;
  logic          ptick;

  assign ptick  = (pre_q == PW'(DIV - 1));
  assign stat_o = stat_q;

  always_ff @(posedge clk) begin
    if (rst || !fault_i) begin
      pre_q   <= '0;
      half_q  <= '0;
      blink_q <= 1'b1;
    end else begin
      pre_q <= ptick ? '0 : pre_q + 1'b1;
      if (ptick) begin
        if (half_q == HW'(HALF - 1)) begin
          half_q  <= '0;
          blink_q <= ~blink_q;
        end else begin
          half_q <= half_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             stat_q <= 1'b1;
    else if (stat_dis_i) stat_q <= 1'b1;
    else if (fault_i)    stat_q <= blink_q;
    else                 stat_q <= ~charging_i;
  end

  // R7
  stat_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stat_dis_i |=> stat_o);
endmodule

// File: rtl/chg_cycle_ctrl.sv
module chg_cycle_ctrl #(
  parameter int TIMER_LIMIT = 43200,
  parameter int BLINK_DIV   = 50000,
  parameter int BLINK_HALF  = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       conv_on,
  input  logic       en_bit,
  input  logic       en_pin_n,
  input  logic       ichg_nz,
  input  logic       ts_fault,
  input  logic       fet_dis,
  input  logic       vbat_lo_pre,
  input  logic       vbat_lo_rech,
  input  logic       ibat_lo_term,
  input  logic       dpm_act,
  input  logic       treg_act,
  input  logic       tick_1s,
  input  logic       stat_dis,
  output logic [1:0] phase,
  output logic       stat_o,
  output logic       int_o,
  output logic       tmr_fault
);
  import chg_pkg::*;

  phase_e st_q, st_d;
  logic   int_q;
  logic   user_en, start_ok;
  logic   expire, fault;
  logic   term_ok, abort, begin_cyc, done_hit, running;

  chg_qual u_qual (
    .conv_on   (conv_on),
    .en_bit    (en_bit),
    .en_pin_n  (en_pin_n),
    .ichg_nz   (ichg_nz),
    .ts_fault  (ts_fault),
    .fet_dis   (fet_dis),
    .tmr_fault (fault),
    .user_en   (user_en),
    .start_ok  (start_ok)
  );

  assign running   = (st_q == PH_PRE) || (st_q == PH_FAST);
  assign term_ok   = ibat_lo_term & ~vbat_lo_rech & ~dpm_act & ~treg_act;
  assign abort     = ~start_ok | expire;
  assign begin_cyc = ~abort & ((st_q == PH_DIS) || ((st_q == PH_DONE) && vbat_lo_rech));
  assign done_hit  = ~abort & (st_q == PH_FAST) & term_ok;

  chg_safety_tmr #(.LIMIT(TIMER_LIMIT)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .run_i     (running),
    .clr_i     (begin_cyc),
    .tick_i    (tick_1s),
    .user_en_i (user_en),
    .expire_o  (expire),
    .fault_o   (fault)
  );

  always_comb begin
    st_d = st_q;
    if (abort)          st_d = PH_DIS;
    else if (begin_cyc) st_d = vbat_lo_pre ? PH_PRE : PH_FAST;
    else begin
      case (st_q)
        PH_PRE:  if (!vbat_lo_pre) st_d = PH_FAST;
        PH_FAST: if (term_ok)      st_d = PH_DONE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PH_DIS;
      int_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      int_q <= done_hit;
    end
  end

  chg_stat_drv #(.DIV(BLINK_DIV), .HALF(BLINK_HALF)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .charging_i (running),
    .fault_i    (fault | ts_fault),
    .stat_dis_i (stat_dis),
    .stat_o     (stat_o)
  );

  assign phase     = st_q;
  assign int_o     = int_q;
  assign tmr_fault = fault;

  // R1
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    !start_ok |=> st_q == PH_DIS);
  // R3
  done_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_DONE && $past(st_q) == PH_FAST) |-> $past(!dpm_act && !treg_act && ibat_lo_term));
  // R8
  int_width_chk: assert property (@(posedge clk) disable iff (rst)
    int_o |=> !int_o);
  // R8
  int_phase_chk: assert property (@(posedge clk) disable iff (rst)
    int_o |-> st_q == PH_DONE);
  // R11
  expire_wins_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (st_q == PH_DIS) && !int_o && fault);
endmodule

// File: tb/chg_cycle_ctrl_bench.sv
module chg_cycle_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic conv_on = 0, en_bit = 0, en_pin_n = 0, ichg_nz = 0, ts_fault = 0, fet_dis = 0;
  logic vbat_lo_pre = 0, vbat_lo_rech = 0, ibat_lo_term = 0, dpm_act = 0, treg_act = 0;
  logic tick_1s = 0, stat_dis = 0;
  logic [1:0] phase;
  logic stat_o, int_o, tmr_fault;
  int n_chk = 0, n_err = 0, int_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_cycle_ctrl #(.TIMER_LIMIT(LIM), .BLINK_DIV(2), .BLINK_HALF(512)) u_chg_cycle_ctrl (
    .clk(clk), .rst(rst), .conv_on(conv_on), .en_bit(en_bit), .en_pin_n(en_pin_n),
    .ichg_nz(ichg_nz), .ts_fault(ts_fault), .fet_dis(fet_dis), .vbat_lo_pre(vbat_lo_pre),
    .vbat_lo_rech(vbat_lo_rech), .ibat_lo_term(ibat_lo_term), .dpm_act(dpm_act),
    .treg_act(treg_act), .tick_1s(tick_1s), .stat_dis(stat_dis), .phase(phase),
    .stat_o(stat_o), .int_o(int_o), .tmr_fault(tmr_fault));

  always @(negedge clk) if (!rst && int_o) int_cnt++;

  // conv en pin_n ichg ts fet pre rech term dpm treg _ phase _ interrupts so far
  localparam logic [14:0] VEC [22] = '{
    15'b0_0_0_0_0_0_0_0_0_0_0_00_00,
    15'b1_1_0_1_0_0_1_1_0_0_0_01_00,
    15'b1_1_0_1_0_0_0_1_0_0_0_10_00,
    15'b1_1_0_1_0_0_0_1_1_0_0_10_00,
    15'b1_1_0_1_0_0_0_0_1_1_0_10_00,
    15'b1_1_0_1_0_0_0_0_1_0_1_10_00,
    15'b1_1_0_1_0_0_0_0_1_0_0_11_01,
    15'b1_1_0_1_0_0_0_0_0_0_0_11_01,
    15'b1_1_0_1_0_0_1_1_0_0_0_01_01,
    15'b1_1_0_0_0_0_0_1_0_0_0_00_01,
    15'b1_1_0_1_0_0_0_1_0_0_0_10_01,
    15'b1_1_0_1_1_0_0_1_0_0_0_00_01,
    15'b1_1_0_1_0_1_0_1_0_0_0_00_01,
    15'b1_1_1_1_0_0_0_1_0_0_0_00_01,
    15'b1_1_0_1_0_0_0_1_0_0_0_10_01,
    15'b1_1_0_1_0_0_0_0_1_0_0_11_10,
    15'b1_0_0_1_0_0_0_0_0_0_0_00_10,
    15'b1_1_0_1_0_0_0_0_0_0_0_10_10,
    15'b0_1_0_1_0_0_0_0_0_0_0_00_10,
    15'b1_1_0_1_0_0_0_0_1_0_0_11_11,
    15'b1_1_1_1_0_0_0_0_1_0_0_00_11,
    15'b1_1_0_1_0_0_0_1_0_0_0_10_11
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick_1s = 1'b1;
      @(negedge clk) tick_1s = 1'b0;
    end
  endtask

  task automatic count_edges(input int cycles, output int edges);
    logic prev;
    edges = 0;
    prev = stat_o;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (stat_o !== prev) edges++;
      prev = stat_o;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int e;
    settle(3);
    rst = 1'b0;
    settle(1);
    // R12 reset state
    chk("R12 phase", phase, 0);
    chk("R12 stat", stat_o, 1);
    chk("R12 int", int_o, 0);
    chk("R12 fault", tmr_fault, 0);

    // vector walk: R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < 22; i++) begin
      {conv_on, en_bit, en_pin_n, ichg_nz, ts_fault, fet_dis,
       vbat_lo_pre, vbat_lo_rech, ibat_lo_term, dpm_act, treg_act} = VEC[i][14:4];
      settle(3);
      chk($sformatf("R1/R2/R3/R4/R5 phase vec %0d", i), phase, int'(VEC[i][3:2]));
      chk($sformatf("R8 interrupts vec %0d", i), int_cnt, int'(VEC[i][1:0]));
      if (!VEC[i][10])
        chk($sformatf("R6 stat vec %0d", i), stat_o,
            (VEC[i][3:2] == 2'b01 || VEC[i][3:2] == 2'b10) ? 0 : 1);
    end

    // R7 disable overrides charging-low
    stat_dis = 1'b1; settle(3);
    chk("R7 stat forced high", stat_o, 1);
    stat_dis = 1'b0; settle(3);
    chk("R6 stat low while charging", stat_o, 0);

    // R9 timer cleared at each start
    tick(5);
    en_bit = 1'b0; settle(2); en_bit = 1'b1; settle(3);
    tick(5);
    settle(2);
    chk("R9 clear on start fault", tmr_fault, 0);
    chk("R9 clear on start phase", phase, 2);

    // R9 counts precharge plus fast charge, expires at limit
    en_bit = 1'b0; settle(2);
    vbat_lo_pre = 1'b1; en_bit = 1'b1; settle(3);
    chk("R2 precharge entry", phase, 1);
    tick(4);
    vbat_lo_pre = 1'b0; settle(2);
    tick(3); settle(2);
    chk("R9 before limit", tmr_fault, 0);
    tick(1); settle(3);
    chk("R9 expiry fault", tmr_fault, 1);
    chk("R9 expiry phase", phase, 0);
    count_edges(2200, e);
    chk("R6 blink toggles", (e >= 2) ? 1 : 0, 1);
    stat_dis = 1'b1; settle(3);
    count_edges(2200, e);
    chk("R7 no blink when disabled", e, 0);
    chk("R7 level when disabled", stat_o, 1);
    stat_dis = 1'b0;

    // R10 fault survives recharge condition, cleared by pin toggle
    vbat_lo_rech = 1'b1; settle(6);
    chk("R10 fault persists", tmr_fault, 1);
    chk("R10 no restart", phase, 0);
    en_pin_n = 1'b1; settle(2);
    chk("R10 fault cleared", tmr_fault, 0);
    en_pin_n = 1'b0; settle(3);
    chk("R10 restart after toggle", phase, 2);

    // R9 no counting while done
    ibat_lo_term = 1'b1; vbat_lo_rech = 1'b0; settle(3);
    chk("R8 done interrupt", int_cnt, 4);
    tick(20); settle(2);
    chk("R9 done no count fault", tmr_fault, 0);
    chk("R9 done no count phase", phase, 3);

    // R4 recharge restart, then R11 expiry against termination
    ibat_lo_term = 1'b0; vbat_lo_rech = 1'b1; settle(3);
    chk("R4 recharge restart", phase, 2);
    tick(LIM - 1); settle(2);
    chk("R11 still charging", phase, 2);
    @(negedge clk);
    ibat_lo_term = 1'b1; vbat_lo_rech = 1'b0; tick_1s = 1'b1;
    @(negedge clk) tick_1s = 1'b0;
    settle(3);
    chk("R11 phase", phase, 0);
    chk("R11 fault", tmr_fault, 1);
    chk("R11 no interrupt", int_cnt, 4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule